// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between a UART's serial receive path, its two byte FIFOs and the processor's data-register write path. A two-bit channel mode field, taken from bits 9:8 of the mode register, selects one of four steering modes. In normal mode, received bytes go to the receive FIFO and processor writes go to the transmit FIFO. In echo mode, every received byte goes to both FIFOs. In local loopback, processor writes are turned back into the receive FIFO. In remote loopback, received bytes are sent straight back through the transmit FIFO.

The block also works out how many more bytes the serial receiver may deliver. That count is a credit: it starts at the larger of the two FIFO depths and is capped by the free space of whichever FIFOs the current mode fills. A ready flag derived from the credit stalls the upstream deserializer.

Transmit pushes are gated by the transmit enable and disable control bits. A push into a full transmit FIFO is dropped and flagged. A transmit-reset request produces a one-cycle flush pulse toward the transmit FIFO. The FIFOs themselves sit outside the block.

The design is built around a four-state mode machine. Its states are ST_NORMAL, ST_ECHO, ST_LOCAL and ST_REMOTE. On every clock edge the machine moves to the state named by the mode field, so any state can go to any other state. The transitions are named by their target: GO_NORMAL (field 0), GO_ECHO (field 1), GO_LOCAL (field 2) and GO_REMOTE (field 3). The machine holds its state while the field is unchanged. Reset places it in ST_NORMAL.

Top module: `chan_router`

## Requirements
- R1: The mode field encodes 0 as normal, 1 as echo, 2 as local loopback and 3 as remote loopback. A new field value governs routing from the clock edge after the one that samples it, so a byte presented on the same edge as a mode change is still routed by the old mode. Reset selects normal mode.
- R2: In normal and echo modes, a serial byte presented with `ser_valid` produces `rx_push` with that byte on `rx_data` one cycle later. In local loopback, serial bytes push nothing.
- R3: In remote loopback and echo modes, a serial byte produces `tx_push` with that byte on `tx_data` one cycle later. In echo mode, `rx_push` and `tx_push` rise in the same cycle carrying the same byte.
- R4: A processor write (`cpu_wr`) goes to the transmit FIFO in normal mode and to the receive FIFO in local loopback, one cycle later. It produces no push in echo or remote loopback.
- R5: `rx_credit` equals the larger FIFO depth. In normal and echo modes it is further limited to `rx_free`. In remote loopback and echo modes it is further limited to `tx_free`. In local loopback it equals the larger depth.
- R6: `rx_ready` is low exactly when `rx_credit` is zero.
- R7: A transmit push happens only when `tx_on` (control bit 4) is high and `tx_off` (control bit 5) is low. While blocked, no push and no overflow event occur.
- R8: An enabled transmit push while `tx_free` is zero is dropped (`tx_push` stays low) and raises `tx_ovf` for one cycle, one cycle later.
- R9: A control write (`ctl_wr`) with `ctl_txrst` (control bit 1) set produces a one-cycle `tx_flush` pulse one cycle later. `tx_flush` then returns low by itself.
- R10: Immediately after reset, `rx_push`, `tx_push`, `tx_ovf` and `tx_flush` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chmode | input | 2 | Channel mode field (mode register bits 9:8) |
| tx_on | input | 1 | Transmit enable (control bit 4) |
| tx_off | input | 1 | Transmit disable (control bit 5) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_txrst | input | 1 | Transmit reset request in write data (control bit 1) |
| ser_valid | input | 1 | Received serial byte valid |
| ser_data | input | DATA_W | Received serial byte |
| cpu_wr | input | 1 | Processor data-register write strobe |
| cpu_data | input | DATA_W | Processor write byte |
| rx_free | input | clog2(RX_DEPTH+1) | Receive FIFO free entries |
| tx_free | input | clog2(TX_DEPTH+1) | Transmit FIFO free entries |
| rx_push | output | 1 | Receive FIFO push strobe |
| rx_data | output | DATA_W | Receive FIFO push byte |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | DATA_W | Transmit FIFO push byte |
| tx_ovf | output | 1 | Transmit overflow event |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| rx_credit | output | clog2(max depth+1) | Bytes the receive side may accept |
| rx_ready | output | 1 | Receive side may accept a byte |

## Verification
Pushes, `tx_ovf` and `tx_flush` are registered, so each appears on the first clock edge after the strobe that causes it. A change of `chmode` is sampled on one edge and routes traffic from the next edge on. `rx_credit` and `rx_ready` follow the free counts combinationally, but they follow the mode one edge late. The bench drives stimulus on a falling edge and samples one falling edge later, with one rising edge in between. It presents a new mode one full cycle before any traffic. The exception is one check that deliberately presents a byte together with a mode change to show the old mode still governs that byte.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ECHO   = 2'd1,
        ST_LOCAL  = 2'd2,
        ST_REMOTE = 2'd3
    } cmr_state_e;

    function automatic int unsigned cmr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cmr_mode_fsm.sv
module cmr_mode_fsm
    import cmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chmode,
    output logic       ser_to_rx,
    output logic       ser_to_tx,
    output logic       cpu_to_rx,
    output logic       cpu_to_tx,
    output logic       lim_rx,
    output logic       lim_tx
);
    cmr_state_e st, st_nx;

    // transition selection: GO_NORMAL / GO_ECHO / GO_LOCAL / GO_REMOTE
    always_comb begin
        unique case (chmode)
            2'd0:    st_nx = ST_NORMAL;
            2'd1:    st_nx = ST_ECHO;
            2'd2:    st_nx = ST_LOCAL;
            default: st_nx = ST_REMOTE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_NORMAL;
        else        st <= st_nx;
    end

    always_comb begin
        ser_to_rx = 1'b0;
        ser_to_tx = 1'b0;
        cpu_to_rx = 1'b0;
        cpu_to_tx = 1'b0;
        unique case (st)
            ST_NORMAL: begin
                ser_to_rx = 1'b1;
                cpu_to_tx = 1'b1;
            end
            ST_ECHO: begin
                ser_to_rx = 1'b1;
                ser_to_tx = 1'b1;
            end
            ST_LOCAL: begin
                cpu_to_rx = 1'b1;
            end
            ST_REMOTE: begin
                ser_to_tx = 1'b1;
            end
        endcase
        // credit is limited by whichever FIFO the serial side fills
        lim_rx = ser_to_rx;
        lim_tx = ser_to_tx;
    end
endmodule

// File: rtl/cmr_credit.sv
module cmr_credit #(
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned TX_DEPTH = 32,
    localparam int unsigned MAXD = cmr_pkg::cmr_max(RX_DEPTH, TX_DEPTH),
    localparam int unsigned RXW  = $clog2(RX_DEPTH + 1),
    localparam int unsigned TXW  = $clog2(TX_DEPTH + 1),
    localparam int unsigned CW   = $clog2(MAXD + 1)
) (
    input  logic           lim_rx,
    input  logic           lim_tx,
    input  logic [RXW-1:0] rx_free,
    input  logic [TXW-1:0] tx_free,
    output logic [CW-1:0]  credit
);
    logic [CW-1:0] rx_c, tx_c, stage;

    always_comb begin
        rx_c  = CW'(rx_free);
        tx_c  = CW'(tx_free);
        stage = CW'(MAXD);
        if (lim_rx && (rx_c < stage)) stage = rx_c;
        if (lim_tx && (tx_c < stage)) stage = tx_c;
        credit = stage;
    end
endmodule

// File: rtl/cmr_steer.sv
module cmr_steer #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TX_DEPTH = 32,
    localparam int unsigned TXW = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_to_rx,
    input  logic              ser_to_tx,
    input  logic              cpu_to_rx,
    input  logic              cpu_to_tx,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              ctl_wr,
    input  logic              ctl_txrst,
    input  logic              ser_valid,
    input  logic [DATA_W-1:0] ser_data,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [TXW-1:0]    tx_free,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_ovf,
    output logic              tx_flush
);
    logic              want_rx, want_tx, tx_ok, tx_full;
    logic [DATA_W-1:0] rx_d, tx_d;

    always_comb begin
        want_rx = (ser_valid && ser_to_rx) || (cpu_wr && cpu_to_rx);
        want_tx = (ser_valid && ser_to_tx) || (cpu_wr && cpu_to_tx);
        rx_d    = cpu_to_rx ? cpu_data : ser_data;
        tx_d    = cpu_to_tx ? cpu_data : ser_data;
        tx_ok   = tx_on && !tx_off;
        tx_full = (tx_free == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_push  <= 1'b0;
            rx_data  <= '0;
            tx_push  <= 1'b0;
            tx_data  <= '0;
            tx_ovf   <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_push  <= want_rx;
            rx_data  <= rx_d;
            tx_push  <= want_tx && tx_ok && !tx_full;
            tx_data  <= tx_d;
            tx_ovf   <= want_tx && tx_ok && tx_full;
            tx_flush <= ctl_wr && ctl_txrst;
        end
    end
endmodule

// File: rtl/chan_router.sv
module chan_router #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned TX_DEPTH = 32,
    localparam int unsigned MAXD = cmr_pkg::cmr_max(RX_DEPTH, TX_DEPTH),
    localparam int unsigned RXW  = $clog2(RX_DEPTH + 1),
    localparam int unsigned TXW  = $clog2(TX_DEPTH + 1),
    localparam int unsigned CW   = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chmode,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              ctl_wr,
    input  logic              ctl_txrst,
    input  logic              ser_valid,
    input  logic [DATA_W-1:0] ser_data,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [RXW-1:0]    rx_free,
    input  logic [TXW-1:0]    tx_free,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_ovf,
    output logic              tx_flush,
    output logic [CW-1:0]     rx_credit,
    output logic              rx_ready
);
    logic ser_to_rx, ser_to_tx, cpu_to_rx, cpu_to_tx, lim_rx, lim_tx;

    cmr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chmode    (chmode),
        .ser_to_rx (ser_to_rx),
        .ser_to_tx (ser_to_tx),
        .cpu_to_rx (cpu_to_rx),
        .cpu_to_tx (cpu_to_tx),
        .lim_rx    (lim_rx),
        .lim_tx    (lim_tx)
    );

    cmr_credit #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_credit (
        .lim_rx  (lim_rx),
        .lim_tx  (lim_tx),
        .rx_free (rx_free),
        .tx_free (tx_free),
        .credit  (rx_credit)
    );

    cmr_steer #(.DATA_W(DATA_W), .TX_DEPTH(TX_DEPTH)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_to_rx (ser_to_rx),
        .ser_to_tx (ser_to_tx),
        .cpu_to_rx (cpu_to_rx),
        .cpu_to_tx (cpu_to_tx),
        .tx_on     (tx_on),
        .tx_off    (tx_off),
        .ctl_wr    (ctl_wr),
        .ctl_txrst (ctl_txrst),
        .ser_valid (ser_valid),
        .ser_data  (ser_data),
        .cpu_wr    (cpu_wr),
        .cpu_data  (cpu_data),
        .tx_free   (tx_free),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .tx_push   (tx_push),
        .tx_data   (tx_data),
        .tx_ovf    (tx_ovf),
        .tx_flush  (tx_flush)
    );

    assign rx_ready = (rx_credit != '0);
endmodule

// File: rtl/cmr_checker.sv
module cmr_checker #(
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned TX_DEPTH = 32,
    localparam int unsigned MAXD = cmr_pkg::cmr_max(RX_DEPTH, TX_DEPTH),
    localparam int unsigned TXW  = $clog2(TX_DEPTH + 1),
    localparam int unsigned CW   = $clog2(MAXD + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ser_valid,
    input logic           cpu_wr,
    input logic           tx_on,
    input logic           tx_off,
    input logic           ctl_wr,
    input logic           ctl_txrst,
    input logic [TXW-1:0] tx_free,
    input logic           rx_push,
    input logic           tx_push,
    input logic           tx_ovf,
    input logic           tx_flush,
    input logic [CW-1:0]  rx_credit,
    input logic           rx_ready
);
    p_push_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || tx_push) |-> $past(ser_valid || cpu_wr));

    p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_credit <= CW'(MAXD));

    p_ready_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_credit == '0) |-> !rx_ready);

    p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push || tx_ovf) |-> $past(tx_on && !tx_off));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> ($past(tx_free) != '0));

    p_ovf_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> (($past(tx_free) == '0) && !tx_push));

    p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(ctl_wr && ctl_txrst));
endmodule

bind chan_router cmr_checker #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_valid (ser_valid),
    .cpu_wr    (cpu_wr),
    .tx_on     (tx_on),
    .tx_off    (tx_off),
    .ctl_wr    (ctl_wr),
    .ctl_txrst (ctl_txrst),
    .tx_free   (tx_free),
    .rx_push   (rx_push),
    .tx_push   (tx_push),
    .tx_ovf    (tx_ovf),
    .tx_flush  (tx_flush),
    .rx_credit (rx_credit),
    .rx_ready  (rx_ready)
);

// File: tb/sim_chan_router.sv
`timescale 1ns/1ps
module sim_chan_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chmode = 2'd0;
    logic       tx_on = 1'b0, tx_off = 1'b0, ctl_wr = 1'b0, ctl_txrst = 1'b0;
    logic       ser_valid = 1'b0, cpu_wr = 1'b0;
    logic [7:0] ser_data = '0, cpu_data = '0;
    logic [4:0] rx_free = 5'd16;
    logic [5:0] tx_free = 6'd32;
    logic       rx_push, tx_push, tx_ovf, tx_flush, rx_ready;
    logic [7:0] rx_data, tx_data;
    logic [5:0] rx_credit;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    chan_router u0 (
        .clk(clk), .rst_n(rst_n), .chmode(chmode), .tx_on(tx_on), .tx_off(tx_off),
        .ctl_wr(ctl_wr), .ctl_txrst(ctl_txrst), .ser_valid(ser_valid), .ser_data(ser_data),
        .cpu_wr(cpu_wr), .cpu_data(cpu_data), .rx_free(rx_free), .tx_free(tx_free),
        .rx_push(rx_push), .rx_data(rx_data), .tx_push(tx_push), .tx_data(tx_data),
        .tx_ovf(tx_ovf), .tx_flush(tx_flush), .rx_credit(rx_credit), .rx_ready(rx_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        chmode = m;
        @(negedge clk);
    endtask

    // present stimulus for one edge, leave outputs of that edge to be checked
    task automatic drive(input logic sv, input logic [7:0] sd, input logic cw, input logic [7:0] cd);
        ser_valid = sv; ser_data = sd; cpu_wr = cw; cpu_data = cd;
        @(negedge clk);
        ser_valid = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 rx_push after reset", rx_push, 0);
        chk("R10 tx_push after reset", tx_push, 0);
        chk("R10 tx_ovf after reset", tx_ovf, 0);
        chk("R10 tx_flush after reset", tx_flush, 0);
        chk("R1 reset mode normal credit", rx_credit, 16);
    endtask

    task automatic t_normal;
        set_mode(2'd0);
        drive(1'b1, 8'hA5, 1'b1, 8'h3C);
        chk("R2 normal rx_push", rx_push, 1);
        chk("R2 normal rx_data", rx_data, 8'hA5);
        chk("R4 normal tx_push", tx_push, 1);
        chk("R4 normal tx_data", tx_data, 8'h3C);
        @(negedge clk);
        chk("R2 push drops", rx_push, 0);
    endtask

    task automatic t_echo;
        set_mode(2'd1);
        drive(1'b1, 8'h5A, 1'b0, 8'h00);
        chk("R2 echo rx_push", rx_push, 1);
        chk("R3 echo tx_push", tx_push, 1);
        chk("R3 echo rx_data", rx_data, 8'h5A);
        chk("R3 echo tx_data", tx_data, 8'h5A);
        drive(1'b0, 8'h00, 1'b1, 8'h11);
        chk("R4 echo cpu ignored rx", rx_push, 0);
        chk("R4 echo cpu ignored tx", tx_push, 0);
    endtask

    task automatic t_local;
        set_mode(2'd2);
        drive(1'b0, 8'h00, 1'b1, 8'h77);
        chk("R4 local rx_push", rx_push, 1);
        chk("R4 local rx_data", rx_data, 8'h77);
        chk("R4 local tx_push", tx_push, 0);
        drive(1'b1, 8'h99, 1'b0, 8'h00);
        chk("R2 local serial ignored rx", rx_push, 0);
        chk("R2 local serial ignored tx", tx_push, 0);
    endtask

    task automatic t_remote;
        set_mode(2'd3);
        drive(1'b1, 8'hC3, 1'b0, 8'h00);
        chk("R3 remote tx_push", tx_push, 1);
        chk("R3 remote tx_data", tx_data, 8'hC3);
        chk("R3 remote rx_push", rx_push, 0);
        drive(1'b0, 8'h00, 1'b1, 8'h22);
        chk("R4 remote cpu ignored tx", tx_push, 0);
        chk("R4 remote cpu ignored rx", rx_push, 0);
        // byte arrives on the same edge as a mode change: old mode applies
        chmode = 2'd0;
        drive(1'b1, 8'h44, 1'b0, 8'h00);
        chk("R1 old mode tx_push", tx_push, 1);
        chk("R1 old mode rx_push", rx_push, 0);
        drive(1'b1, 8'h45, 1'b0, 8'h00);
        chk("R1 new mode rx_push", rx_push, 1);
        chk("R1 new mode tx_push", tx_push, 0);
    endtask

    task automatic t_credit;
        rx_free = 5'd5; tx_free = 6'd20;
        set_mode(2'd0);
        chk("R5 normal credit", rx_credit, 5);
        set_mode(2'd3);
        chk("R5 remote credit", rx_credit, 20);
        set_mode(2'd2);
        chk("R5 local credit", rx_credit, 32);
        rx_free = 5'd10; tx_free = 6'd3;
        set_mode(2'd1);
        chk("R5 echo credit tx limit", rx_credit, 3);
        rx_free = 5'd2;
        @(negedge clk);
        chk("R5 echo credit rx limit", rx_credit, 2);
        rx_free = 5'd0;
        set_mode(2'd0);
        chk("R5 normal credit zero", rx_credit, 0);
        chk("R6 ready low at zero", rx_ready, 0);
        rx_free = 5'd1;
        @(negedge clk);
        chk("R6 ready high", rx_ready, 1);
        rx_free = 5'd16; tx_free = 6'd32;
        @(negedge clk);
    endtask

    task automatic t_gate;
        set_mode(2'd0);
        tx_on = 1'b0; tx_off = 1'b0;
        drive(1'b0, 8'h00, 1'b1, 8'h12);
        chk("R7 not enabled tx_push", tx_push, 0);
        tx_on = 1'b1; tx_off = 1'b1;
        drive(1'b0, 8'h00, 1'b1, 8'h13);
        chk("R7 disabled tx_push", tx_push, 0);
        tx_free = 6'd0;
        drive(1'b0, 8'h00, 1'b1, 8'h14);
        chk("R7 blocked no ovf", tx_ovf, 0);
        tx_off = 1'b0; tx_free = 6'd32;
        drive(1'b0, 8'h00, 1'b1, 8'h15);
        chk("R7 enabled tx_push", tx_push, 1);
    endtask

    task automatic t_overflow;
        set_mode(2'd0);
        tx_free = 6'd0;
        drive(1'b0, 8'h00, 1'b1, 8'h66);
        chk("R8 full push dropped", tx_push, 0);
        chk("R8 ovf raised", tx_ovf, 1);
        @(negedge clk);
        chk("R8 ovf one cycle", tx_ovf, 0);
        set_mode(2'd3);
        drive(1'b1, 8'h67, 1'b0, 8'h00);
        chk("R8 remote full ovf", tx_ovf, 1);
        tx_free = 6'd1;
        set_mode(2'd0);
        drive(1'b0, 8'h00, 1'b1, 8'h68);
        chk("R8 one free push", tx_push, 1);
        chk("R8 one free no ovf", tx_ovf, 0);
        tx_free = 6'd32;
    endtask

    task automatic t_flush;
        ctl_wr = 1'b1; ctl_txrst = 1'b0;
        @(negedge clk);
        chk("R9 no request no flush", tx_flush, 0);
        ctl_txrst = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_txrst = 1'b0;
        chk("R9 flush pulse", tx_flush, 1);
        @(negedge clk);
        chk("R9 flush self clears", tx_flush, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tx_on = 1'b1;
        @(negedge clk);
        t_normal();
        t_echo();
        t_local();
        t_remote();
        t_credit();
        t_gate();
        t_overflow();
        t_flush();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule